// File: doc/BRIEF.md
# Modem Status Change Detector

This block holds the modem-status logic of a serial communications controller. It watches four active-low handshake lines from a modem: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a two-flop synchronizer. The block reports the true, active-high level of each line. It also keeps a sticky change flag per line, which stays set until the CPU reads the status word.

A read strobe from the bus side returns an 8-bit word. The low nibble holds the change flags and the high nibble holds the levels. The strobe clears the flags on the following clock edge. A change that arrives in the same cycle as the read is never lost.

An interrupt request is raised while any flag is set and the interrupt enable is high. When the loopback input from the modem control register is high, the four external pins are replaced by four internal control bits. Change detection then runs on those control bits, so entering or leaving loopback can raise flags.

Top module: `modem_status_unit`

## Requirements
- R1: Status bit 0 becomes 1 on the clock edge after the clear-to-send level (bit 4) differs from its value one cycle earlier. It stays 1 until a read clears it.
- R2: Status bit 1 becomes 1 on the clock edge after the data-set-ready level (bit 5) changes, in either direction. It stays 1 until a read.
- R3: Status bit 2 becomes 1 only when the ring level (bit 6) goes from 1 to 0. A 0-to-1 transition of that level leaves bit 2 unchanged.
- R4: Status bit 3 becomes 1 on the clock edge after the carrier-detect level (bit 7) changes, in either direction. It stays 1 until a read.
- R5: `irq` is 1 exactly when `irq_en` is 1 and at least one of status bits 3..0 is 1. It falls in the same cycle the flags clear.
- R6: With `loop_en` low, status bits 4, 5, 6 and 7 equal the inverse of `cts_n_in`, `dsr_n_in`, `ri_n_in` and `dcd_n_in`. A pin change shows in the status after the second rising clock edge.
- R7: With `loop_en` high, status bits 4, 5, 6 and 7 equal `ctl_rts`, `ctl_dtr`, `ctl_aux1` and `ctl_aux2`. These values appear combinationally, with no synchronizer delay.
- R8: While `rd_stb` is high, `status` shows the flags before clearing. Bits 3..0 are cleared on the next edge. A change detected in the strobe cycle leaves its flag set.
- R9: Switching `loop_en` in either direction runs change detection on the substituted levels. A level that differs between the pin path and the control path sets its flag, following the rules of R1 to R4.
- R10: Synchronous active-high `rst` clears all flags and stored levels. With all pins inactive (high) and loopback off, no flag and no `irq` appear after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_in | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_in | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_in | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_in | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback select from the modem control register |
| ctl_rts | input | 1 | Control bit substituted for clear-to-send in loopback |
| ctl_dtr | input | 1 | Control bit substituted for data-set-ready in loopback |
| ctl_aux1 | input | 1 | Control bit substituted for ring indicator in loopback |
| ctl_aux2 | input | 1 | Control bit substituted for carrier detect in loopback |
| rd_stb | input | 1 | One-cycle read strobe of the status word |
| irq_en | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Levels in bits 7..4, change flags in bits 3..0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a level change whose detection cycle lines up exactly with a read strobe. This requires counting the two synchronizer stages from the pin edge. The bench places the strobe in that exact cycle, then checks that the flag survives the clear.

Loopback entry and exit with control bits that differ from the pin levels are also driven on purpose. These cover both directions of the ring edge. Long random runs then mix sparse pin toggles, loopback switches and reads against a cycle-level bench model.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;

    localparam int MSR_LINES = 4;
    localparam int MSR_SYNC_STAGES = 2;

    typedef enum logic {
        DET_ANY_EDGE  = 1'b0,
        DET_FALL_ONLY = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    typedef struct packed {
        modem_lines_t level;
        modem_lines_t delta;
    } msr_word_t;

    // Ring (index 2) reports only the on-to-off transition.
    function automatic det_mode_e line_mode(input int idx);
        return (idx == 2) ? DET_FALL_ONLY : DET_ANY_EDGE;
    endfunction

    function automatic logic line_event(input det_mode_e mode, input logic prev_v, input logic cur_v);
        logic ev;
        case (mode)
            DET_FALL_ONLY: ev = prev_v & ~cur_v;
            default:       ev = prev_v ^ cur_v;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/msr_sync.sv
`timescale 1ns/1ps
module msr_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
`timescale 1ns/1ps
module msr_delta
    import msr_pkg::*;
#(
    parameter int W = MSR_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic         rd_clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] prev_lvl;
    logic [W-1:0] evt;

    for (genvar i = 0; i < W; i++) begin : g_line
        localparam det_mode_e MODE = line_mode(i);
        assign evt[i] = line_event(MODE, prev_lvl[i], cur[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= '0;
            flags    <= '0;
        end else begin
            prev_lvl <= cur;
            flags    <= (rd_clr ? '0 : flags) | evt;
        end
    end
endmodule

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
module modem_status_unit
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cts_n_in,
    input  logic       dsr_n_in,
    input  logic       ri_n_in,
    input  logic       dcd_n_in,
    input  logic       loop_en,
    input  logic       ctl_rts,
    input  logic       ctl_dtr,
    input  logic       ctl_aux1,
    input  logic       ctl_aux2,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] status,
    output logic       irq
);
    modem_lines_t pins_n, synced_n, ctl_lines, level, delta;
    msr_word_t    word;

    assign pins_n    = '{dcd: dcd_n_in, ri: ri_n_in, dsr: dsr_n_in, cts: cts_n_in};
    assign ctl_lines = '{dcd: ctl_aux2, ri: ctl_aux1, dsr: ctl_dtr, cts: ctl_rts};

    msr_sync #(
        .W(MSR_LINES),
        .STAGES(MSR_SYNC_STAGES),
        .RST_VAL({MSR_LINES{1'b1}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d(pins_n),
        .q(synced_n)
    );

    // Loopback substitutes control bits for the inverted pin levels.
    assign level = loop_en ? ctl_lines : modem_lines_t'(~synced_n);

    msr_delta #(.W(MSR_LINES)) u_delta (
        .clk(clk),
        .rst(rst),
        .cur(level),
        .rd_clr(rd_stb),
        .flags(delta)
    );

    assign word   = '{level: level, delta: delta};
    assign status = word;
    assign irq    = irq_en & (|delta);
endmodule

// File: rtl/msr_checker.sv
`timescale 1ns/1ps
module msr_checker (
    input logic       clk,
    input logic       rst,
    input logic       loop_en,
    input logic       ctl_rts,
    input logic       ctl_dtr,
    input logic       ctl_aux1,
    input logic       ctl_aux2,
    input logic       rd_stb,
    input logic       irq_en,
    input logic [7:0] status,
    input logic       irq
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (armed && !rd_stb) |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0]))); // R1
    AST_CTS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (armed && status[4] != $past(status[4])) |=> status[0]); // R1
    AST_DSR_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (armed && status[5] != $past(status[5])) |=> status[1]); // R2
    AST_RI_RISE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (armed && status[6] && !$past(status[6]) && !status[2]) |=> !status[2]); // R3
    AST_RI_FALL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (armed && !status[6] && $past(status[6])) |=> status[2]); // R3
    AST_DCD_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (armed && status[7] != $past(status[7])) |=> status[3]); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status[3:0] != 4'b0)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq); // R5
    AST_LOOP_MAP: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (status[7:4] == {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts})); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (armed && rd_stb && $stable(status[7:4])) |=> (status[3:0] == 4'b0)); // R8
endmodule

bind modem_status_unit msr_checker u_chk (.*);

// File: tb/tb_modem_status_unit.sv
`timescale 1ns/1ps
module tb_modem_status_unit;
    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins_n = 4'hF;   // bit0 cts, bit1 dsr, bit2 ri, bit3 dcd
    logic [3:0] ctl = 4'h0;      // bit0 rts, bit1 dtr, bit2 aux1, bit3 aux2
    logic       loop_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] status;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;

    logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_prev = 4'h0, m_flags = 4'h0;

    always #(HALF) clk = ~clk;

    modem_status_unit dut (
        .clk(clk), .rst(rst),
        .cts_n_in(pins_n[0]), .dsr_n_in(pins_n[1]), .ri_n_in(pins_n[2]), .dcd_n_in(pins_n[3]),
        .loop_en(loop_en),
        .ctl_rts(ctl[0]), .ctl_dtr(ctl[1]), .ctl_aux1(ctl[2]), .ctl_aux2(ctl[3]),
        .rd_stb(rd_stb), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    function automatic logic [7:0] exp_status();
        return {(loop_en ? ctl : ~m_s2), m_flags};
    endfunction

    function automatic string bit_req(input int b);
        case (b)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return loop_en ? "R7" : "R6";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [7:0] es;
        es = exp_status();
        for (int b = 0; b < 8; b++) begin
            if (status[b] !== es[b]) begin
                check(1'b0, bit_req(b), status, es);
                return;
            end
        end
        check(1'b1, "R1", status, es);
        check(irq === (irq_en & |m_flags), "R5", {7'b0, irq}, {7'b0, irq_en & |m_flags});
    endtask

    // One clock: advance bench model with the inputs held at the edge, then compare.
    task automatic cycle();
        logic [3:0] cur, ev;
        @(posedge clk);
        if (rst) begin
            m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 4'h0; m_flags = 4'h0;
        end else begin
            cur = loop_en ? ctl : ~m_s2;
            ev = cur ^ m_prev;
            ev[2] = m_prev[2] & ~cur[2];
            m_flags = (rd_stb ? 4'h0 : m_flags) | ev;
            m_prev = cur;
            m_s2 = m_s1;
            m_s1 = pins_n;
        end
        #1;
        compare_model();
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic read_clear();
        rd_stb = 1'b1;
        cycle();
        rd_stb = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        cycles(3);
        rst = 1'b0;
        cycle();
        cycles(2);
        check(status == 8'h00, "R10 quiet after reset", status, 8'h00);
        check(irq == 1'b0, "R10 no irq after reset", {7'b0, irq}, 8'h00);

        // R6 latency and R1 flag
        pins_n[0] = 1'b0;
        cycle();
        check(status[4] == 1'b0, "R6 first stage", status, 8'h00);
        cycle();
        check(status[4] == 1'b1, "R6 level after two edges", status, 8'h10);
        cycle();
        check(status[0] == 1'b1, "R1 cts flag", status, 8'h11);
        irq_en = 1'b1;
        #1;
        check(irq == 1'b1, "R5 irq with flag", {7'b0, irq}, 8'h01);

        // R8 read returns pre-clear, then clears
        rd_stb = 1'b1;
        #1;
        check(status[0] == 1'b1, "R8 pre-clear value", status, 8'h11);
        cycle();
        rd_stb = 1'b0;
        check(status[3:0] == 4'h0, "R8 cleared", status, 8'h10);
        check(irq == 1'b0, "R5 irq falls", {7'b0, irq}, 8'h00);

        // R3 ring: rise silent, fall flags
        pins_n[2] = 1'b0;
        cycles(4);
        check(status[2] == 1'b0, "R3 rise silent", status, 8'h50);
        pins_n[2] = 1'b1;
        cycles(4);
        check(status[2] == 1'b1, "R3 fall flags", status, 8'h14);
        read_clear();

        // R2 and R4
        pins_n[1] = 1'b0; pins_n[3] = 1'b0;
        cycles(4);
        check(status[1] == 1'b1, "R2 dsr flag", status, 8'hBA);
        check(status[3] == 1'b1, "R4 dcd flag", status, 8'hBA);
        read_clear();
        pins_n[1] = 1'b1; pins_n[3] = 1'b1;
        cycles(4);
        check(status[3:0] == 4'b1010, "R2 R4 release flags", status, 8'h1A);
        read_clear();

        // R8 change coincident with read
        pins_n[0] = 1'b1;
        cycles(2);
        rd_stb = 1'b1;
        cycle();
        rd_stb = 1'b0;
        check(status[0] == 1'b1, "R8 coincident change kept", status, 8'h01);
        read_clear();

        // R9 / R7 loopback entry and exit
        ctl = 4'b0101;
        loop_en = 1'b1;
        #1;
        check(status[7:4] == 4'b0101, "R7 loop mapping", status, 8'h50);
        cycle();
        check(status == 8'h51, "R9 entry flags", status, 8'h51);
        read_clear();
        loop_en = 1'b0;
        cycle();
        check(status == 8'h05, "R9 exit flags", status, 8'h05);
        read_clear();

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) pins_n[$urandom_range(0, 3)] ^= 1'b1;
            if ($urandom_range(0, 15) == 0) ctl[$urandom_range(0, 3)] ^= 1'b1;
            if ($urandom_range(0, 63) == 0) loop_en = ~loop_en;
            if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
            rd_stb = ($urandom_range(0, 7) == 0);
            rst = ($urandom_range(0, 999) == 0);
            cycle();
        end
        rst = 1'b0; rd_stb = 1'b0;
        cycles(2);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule